// File: doc/BRIEF.md
# Wait-State Bus Cycle Master

This block turns single-beat commands into read and write cycles on an 8-bit system bus that uses an address-latch strobe. A command names either the memory space or the I/O space, a direction, an address and a write byte. The block opens each cycle with a one-clock ALE pulse. It then drives one of four active-low command strobes: memory read, memory write, I/O read or I/O write. It finishes with a response that carries the read byte and a timeout flag.

A cycle lasts four clocks by default: C1 for the address, then C2, C3 and C4 with the strobe low. A slow target holds the ready input low to stretch the cycle. Each clock in which ready is low at the end of C2, or at the end of a wait clock, adds one more wait clock, up to `MAX_WAIT` (default 6). Once that limit is reached the cycle closes anyway and the response is flagged as timed out. Memory addresses use the full 20 bits. I/O addresses use only the low 16 bits, and the upper bus address bits are zero during I/O cycles.

The command side is valid/ready. The block accepts a command on a clock edge where both `req_valid` and `req_ready` are high, and `req_ready` is high only while no cycle is in flight. The response side has no back-pressure. `rsp_valid` is a one-clock pulse and the consumer must take it in that clock.

Top module: `bcm_bus_master`

## Requirements
- R1: While reset is held, and in the first clock after it is released, all four strobes are high, `bus_ale` is 0, `bus_wdata_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A command is taken on an edge where `req_valid` and `req_ready` are both 1. In the next clock (C1) `bus_ale` is 1 for exactly one clock. `req_ready` stays 0 from C1 until the clock in which the response is presented.
- R3: The bus address is driven from C1 to C4 and is held stable while the strobe is low. For memory commands it equals all 20 request address bits. For I/O commands bits 15:0 come from the request and bits 19:16 are 0.
- R4: Exactly one strobe is low in C2, in every wait clock, in C3 and in C4, and none is low in any other clock. The strobe follows {space, write}: memory read uses `memr_n`, memory write uses `memw_n`, I/O read uses `ior_n` and I/O write uses `iow_n`.
- R5: With ready high, the strobe is low for 3 clocks. `rsp_valid` rises 4 clocks after the clock in which ALE is high, which is 5 clocks after the accepting edge.
- R6: Every clock in which `bus_rdy` is 0 at the end of C2, or at the end of a wait clock, adds one wait clock after C2, up to `MAX_WAIT`. The strobe is then low for 3 + waits clocks.
- R7: If `bus_rdy` is still 0 at the end of the `MAX_WAIT`-th wait clock, the cycle continues to C3 and C4 and `rsp_timeout` is 1 with the response. In every other case `rsp_timeout` is 0, including the command that follows a timed-out one.
- R8: For reads, `rsp_rdata` is the value of `bus_rdata` at the end of C4. For writes, `rsp_rdata` is 0.
- R9: `bus_wdata_oe` is 1 exactly in the strobe clocks of a write, and `bus_wdata` then equals the request write byte. It is 0 during reads and while the bus is idle.
- R10: `rsp_valid` is a single-clock pulse per command. It is never high in two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Command can be taken (bus idle) |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Command address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_rdata | output | 8 | Read byte (0 for writes) |
| rsp_timeout | output | 1 | Wait limit was reached with ready still low |
| bus_ale | output | 1 | Address-latch strobe, high in C1 |
| bus_addr | output | 20 | Bus address, 0 when idle |
| bus_wdata | output | 8 | Write data toward the bus |
| bus_wdata_oe | output | 1 | Output enable for `bus_wdata`; the bus is released when 0 |
| bus_rdata | input | 8 | Read data from the bus |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| bus_rdy | input | 1 | Target ready; 0 asks for a wait clock |

## Verification
Each result has a fixed due time. ALE is due in the clock after the accepting edge. The strobe is due one clock after ALE and stays low for 3 + w clocks, where w is min(hold-low count, `MAX_WAIT`). The response is due 4 + w clocks after the ALE clock and is captured from data seen at the end of C4. The bench models the target so that it holds ready low for a chosen number of strobe clocks. A monitor samples on the falling edge and counts clocks from ALE. When the response pulse arrives, it compares that count, the strobe-clock count, the strobe that was used, the address and the read byte against the item the driver queued.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_C1   = 3'd1,
    ST_C2   = 3'd2,
    ST_WAIT = 3'd3,
    ST_C3   = 3'd4,
    ST_C4   = 3'd5
  } bus_phase_e;

  // True in every clock where a command strobe is driven low.
  function automatic logic strobe_phase(bus_phase_e p);
    return (p == ST_C2) || (p == ST_WAIT) || (p == ST_C3) || (p == ST_C4);
  endfunction

endpackage

// File: rtl/bcm_seq.sv
module bcm_seq
  import bcm_pkg::*;
#(
  parameter int MAX_WAIT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rdy,
  output bus_phase_e phase,
  output logic       timed_out
);
  localparam int CW = $clog2(MAX_WAIT + 2);
  localparam logic [CW-1:0] WLIM = CW'(MAX_WAIT);

  logic [CW-1:0] wcnt, wcnt_n;
  bus_phase_e    phase_n;
  logic          to_n;

  always_comb begin
    phase_n = phase;
    wcnt_n  = wcnt;
    to_n    = timed_out;
    case (phase)
      ST_IDLE: if (start) begin
        phase_n = ST_C1;
        wcnt_n  = '0;
        to_n    = 1'b0;
      end
      ST_C1: phase_n = ST_C2;
      ST_C2, ST_WAIT: begin
        if (rdy) begin
          phase_n = ST_C3;
        end else if (wcnt < WLIM) begin
          phase_n = ST_WAIT;
          wcnt_n  = wcnt + CW'(1);
        end else begin
          phase_n = ST_C3;
          to_n    = 1'b1;
        end
      end
      ST_C3:   phase_n = ST_C4;
      ST_C4:   phase_n = ST_IDLE;
      default: phase_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= ST_IDLE;
      wcnt      <= '0;
      timed_out <= 1'b0;
    end else begin
      phase     <= phase_n;
      wcnt      <= wcnt_n;
      timed_out <= to_n;
    end
  end

  // R6: the number of inserted waits never exceeds the limit
  p_wait_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= WLIM);

  // R6: a wait clock that sees ready ends the stretch
  p_wait_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_WAIT && rdy) |=> (phase == ST_C3 && !timed_out));

  // R7: ready still low at the last allowed wait closes the cycle with the flag
  p_timeout_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_WAIT && !rdy && wcnt == WLIM) |=> (phase == ST_C3 && timed_out));

endmodule

// File: rtl/bcm_strobe.sv
module bcm_strobe
  import bcm_pkg::*;
(
  input  bus_phase_e phase,
  input  logic       is_io,
  input  logic       write,
  output logic       ale,
  output logic [3:0] strobe_n,
  output logic       data_oe
);
  logic act;

  assign act     = strobe_phase(phase);
  assign ale     = (phase == ST_C1);
  assign data_oe = act && write;

  // strobe_n[3]=mem read, [2]=mem write, [1]=io read, [0]=io write
  for (genvar gi = 0; gi < 4; gi++) begin : g_strobe
    assign strobe_n[gi] = !(act && ({is_io, write} == 2'(3 - gi)));
  end

endmodule

// File: rtl/bcm_datapath.sv
module bcm_datapath
  import bcm_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int IO_ADDR_W = 16,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_is_io,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  bus_phase_e        phase,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              timed_out,
  output logic              cmd_is_io,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout
);
  logic [ADDR_W-1:0] addr_q, io_addr;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    io_addr                  = '0;
    io_addr[IO_ADDR_W-1:0]   = req_addr[IO_ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      cmd_is_io <= 1'b0;
      cmd_write <= 1'b0;
    end else if (accept) begin
      addr_q    <= req_is_io ? io_addr : req_addr;
      wdata_q   <= req_wdata;
      cmd_is_io <= req_is_io;
      cmd_write <= req_write;
    end
  end

  assign bus_addr  = (phase != ST_IDLE) ? addr_q : '0;
  assign bus_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_timeout <= 1'b0;
    end else begin
      rsp_valid <= (phase == ST_C4);
      if (phase == ST_C4) begin
        rsp_rdata   <= cmd_write ? '0 : bus_rdata;
        rsp_timeout <= timed_out;
      end
    end
  end

  // R3: address is held while the strobe is low
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_phase(phase) |-> $stable(bus_addr));

  // R10: response is a single-clock pulse
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/bcm_bus_master.sv
module bcm_bus_master
  import bcm_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int IO_ADDR_W = 16,
  parameter int DATA_W    = 8,
  parameter int MAX_WAIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_io,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  output logic              bus_ale,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wdata_oe,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              memr_n,
  output logic              memw_n,
  output logic              ior_n,
  output logic              iow_n,
  input  logic              bus_rdy
);
  bus_phase_e phase;
  logic       timed_out, accept, cmd_is_io, cmd_write;
  logic [3:0] strobe_n;

  assign req_ready = (phase == ST_IDLE);
  assign accept    = req_valid && req_ready;

  bcm_seq #(.MAX_WAIT(MAX_WAIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .rdy(bus_rdy),
    .phase(phase), .timed_out(timed_out)
  );

  bcm_datapath #(.ADDR_W(ADDR_W), .IO_ADDR_W(IO_ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .req_is_io(req_is_io), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .phase(phase), .bus_rdata(bus_rdata), .timed_out(timed_out),
    .cmd_is_io(cmd_is_io), .cmd_write(cmd_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout)
  );

  bcm_strobe u_stb (
    .phase(phase), .is_io(cmd_is_io), .write(cmd_write),
    .ale(bus_ale), .strobe_n(strobe_n), .data_oe(bus_wdata_oe)
  );

  assign memr_n = strobe_n[3];
  assign memw_n = strobe_n[2];
  assign ior_n  = strobe_n[1];
  assign iow_n  = strobe_n[0];

  // R4: never more than one command strobe low
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~memr_n, ~memw_n, ~ior_n, ~iow_n}) <= 1);

  // R2: ALE lasts one clock
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);

  // R2: taking a command starts ALE on the next clock
  p_accept_ale_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_ale && !req_ready));

  // R9: data bus is driven only under a write strobe
  p_oe_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wdata_oe |-> (!memw_n || !iow_n));

endmodule

// File: tb/sim_bcm_bus_master.sv
`timescale 1ns/1ps
module sim_bcm_bus_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_is_io, req_write;
  logic        req_ready;
  logic [19:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid, rsp_timeout;
  logic [7:0]  rsp_rdata;
  logic        bus_ale, bus_wdata_oe;
  logic [19:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        memr_n, memw_n, ior_n, iow_n, bus_rdy;

  always #4 clk = ~clk;

  bcm_bus_master u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_io(req_is_io), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .bus_ale(bus_ale), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
    .bus_rdy(bus_rdy)
  );

  typedef struct {
    logic        io;
    logic        wr;
    logic [19:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rd;
    int          lowcnt;
    int          waits;
    logic        to;
  } exp_t;

  exp_t q[$];
  int   nchk = 0;
  int   nerr = 0;
  logic mon_on = 1'b0;

  function automatic logic [7:0] tgt_data(logic [19:0] a, logic io);
    return a[7:0] ^ a[15:8] ^ (io ? 8'hA5 : 8'h3C);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: offer a command, push the expected item when it is taken
  task automatic issue(input logic io, input logic wr, input logic [19:0] a,
                       input logic [7:0] wd, input int lowcnt);
    exp_t e;
    e.io     = io;
    e.wr     = wr;
    e.addr   = io ? {4'h0, a[15:0]} : a;
    e.wd     = wd;
    e.rd     = wr ? 8'h00 : tgt_data(e.addr, io);
    e.lowcnt = lowcnt;
    e.waits  = (lowcnt > 6) ? 6 : lowcnt;
    e.to     = (lowcnt > 6);
    @(negedge clk);
    req_valid = 1'b1;
    req_is_io = io;
    req_write = wr;
    req_addr  = a;
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = 20'h0;
    req_wdata = 8'h00;
  endtask

  // Target model: holds ready low for lowcnt strobe clocks, returns read data
  initial begin : target
    int dcnt;
    dcnt      = 0;
    bus_rdy   = 1'b1;
    bus_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if ((!memr_n || !memw_n || !ior_n || !iow_n) && q.size() != 0) begin
        dcnt++;
        bus_rdy = (dcnt > q[0].lowcnt);
        if (!memr_n || !ior_n) bus_rdata = tgt_data(bus_addr, !ior_n);
        else bus_rdata = 8'h00;
      end else begin
        dcnt      = 0;
        bus_rdy   = 1'b1;
        bus_rdata = 8'h00;
      end
    end
  end

  // Monitor / scoreboard
  initial begin : monitor
    int          since, sclk;
    logic [3:0]  mask;
    logic [19:0] aseen;
    logic        in_cyc, prev_rsp;
    exp_t        e;
    logic [3:0]  exp_mask;
    since = 0; sclk = 0; mask = 0; aseen = 0; in_cyc = 0; prev_rsp = 0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (bus_ale) begin
          in_cyc = 1'b1; since = 0; sclk = 0; mask = 4'h0; aseen = bus_addr;
          chk(!req_ready, "R2", "req_ready in C1", req_ready, 0);
        end else if (in_cyc) begin
          since++;
        end
        if (!memr_n || !memw_n || !ior_n || !iow_n) begin
          sclk++;
          mask = mask | ~{memr_n, memw_n, ior_n, iow_n};
          chk($countones(~{memr_n, memw_n, ior_n, iow_n}) == 1, "R4",
              "strobes low", {memr_n, memw_n, ior_n, iow_n}, 0);
          chk(bus_addr == aseen, "R3", "address held", bus_addr, aseen);
          chk(!req_ready, "R2", "req_ready while busy", req_ready, 0);
          if (q.size() != 0) begin
            chk(bus_wdata_oe == q[0].wr, "R9", "oe under strobe",
                bus_wdata_oe, q[0].wr);
            if (q[0].wr)
              chk(bus_wdata == q[0].wd, "R9", "write byte", bus_wdata, q[0].wd);
          end
        end else begin
          chk(!bus_wdata_oe, "R9", "oe outside strobe", bus_wdata_oe, 0);
        end
        if (rsp_valid) begin
          chk(!prev_rsp, "R10", "rsp two clocks", prev_rsp, 0);
          if (q.size() == 0) begin
            chk(1'b0, "R10", "unexpected response", 1, 0);
          end else begin
            e = q.pop_front();
            exp_mask = e.io ? (e.wr ? 4'b0001 : 4'b0010)
                            : (e.wr ? 4'b0100 : 4'b1000);
            chk(aseen == e.addr, "R3", "bus address", aseen, e.addr);
            chk(mask == exp_mask, "R4", "strobe used", mask, exp_mask);
            chk(sclk == 3 + e.waits, e.waits == 0 ? "R5" : "R6",
                "strobe clocks", sclk, 3 + e.waits);
            chk(since == 4 + e.waits, "R5", "response clock after ALE",
                since, 4 + e.waits);
            chk(rsp_timeout == e.to, "R7", "timeout flag", rsp_timeout, e.to);
            chk(rsp_rdata == e.rd, "R8", "response data", rsp_rdata, e.rd);
            chk(req_ready, "R2", "ready with response", req_ready, 1);
          end
          in_cyc = 1'b0;
        end
        prev_rsp = rsp_valid;
      end
    end
  end

  task automatic run_all();
    rst_n = 1'b0;
    req_valid = 1'b0; req_is_io = 1'b0; req_write = 1'b0;
    req_addr = 20'h0; req_wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk(memr_n && memw_n && ior_n && iow_n, "R1", "strobes in reset",
        {memr_n, memw_n, ior_n, iow_n}, 4'hF);
    chk(!bus_ale && !bus_wdata_oe && !rsp_valid, "R1", "ale/oe/rsp in reset",
        {bus_ale, bus_wdata_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);
    chk(memr_n && memw_n && ior_n && iow_n && !bus_ale, "R1",
        "idle bus after reset", {memr_n, memw_n, ior_n, iow_n, bus_ale}, 5'h1E);
    mon_on = 1'b1;

    issue(1'b0, 1'b0, 20'h12345, 8'h00, 0);   // R5 R8 memory read, no waits
    issue(1'b0, 1'b1, 20'hABCDE, 8'h5A, 0);   // R9 memory write
    issue(1'b1, 1'b0, 20'hF1234, 8'h00, 2);   // R3 R6 I/O read, upper bits dropped
    issue(1'b1, 1'b1, 20'h98765, 8'hC3, 1);   // R4 R6 I/O write
    issue(1'b0, 1'b0, 20'h0F0F0, 8'h00, 6);   // R6 exactly the limit, no timeout
    issue(1'b0, 1'b0, 20'hFFFFF, 8'h00, 7);   // R7 limit exceeded
    issue(1'b1, 1'b1, 20'h5AA55, 8'h81, 20);  // R7 ready stuck low
    issue(1'b1, 1'b0, 20'h00042, 8'h00, 0);   // R7 flag clears next command
    issue(1'b0, 1'b1, 20'h80001, 8'hE7, 3);   // R6 R9 write with waits

    while (q.size() != 0) @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R10", "idle after last response",
          {rsp_valid, req_ready}, 1);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule